// File: doc/BRIEF.md
# Serial EEPROM Page-Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM that speaks the common SPI command set. The host gives a start pulse with a word offset and a word count. The block checks that the run fits inside the device. It then feeds the words through a single-bit serial port. The host presents the next word on `word_in` at all times and advances to the following word each cycle that `word_take` is high.

Each burst starts by asking for the shared bus through a request/grant pair. The block then polls the device status until the device reports ready. It sends a write-enable command and ends it with a chip-select pulse. Next it sends the write opcode, the byte address and the data words. A burst ends at a device page boundary or after the last word. A fixed write-cycle wait follows, and then the bus is released. Any words left are sent in a fresh burst. One done pulse with an error flag closes the whole transfer.

Top module: `eeprom_page_writer`

## Requirements
- R1: Every serial field goes out most-significant bit first. `ee_mosi` is set up while `ee_sck` is low and holds steady while `ee_sck` is high. It returns low after the last bit of a field and stays low while status bits are read in.
- R2: A start with count 0, with offset >= DEV_WORDS, or with count > DEV_WORDS - offset ends one cycle later with done and error high. No bus request and no chip select occur.
- R3: `ee_cs_n` is low only while `bus_req` is high. If the grant is still absent after GNT_TRIES polls, the request is dropped and the transfer ends with error, and the device is never selected.
- R4: Readiness is checked with the status-read opcode 0x05 followed by 8 status bits read MSB first. Only status bit 0 matters: 1 means busy. Each busy answer is followed by a chip-select pulse and a new poll. RDY_TRIES busy answers in a row end the transfer with error.
- R5: Every write burst is preceded by the write-enable opcode 0x06, closed by a chip-select pulse, before the write opcode 0x02 is sent.
- R6: When ADDR_BITS is 8 and the burst's first word index is 128 or more, the write opcode carries 0x08, which is byte-address bit 8.
- R7: The address field is the byte address (twice the word index), ADDR_BITS wide. Each word goes out low byte first, then high byte. Exactly `count` words are taken from the host.
- R8: A burst ends after the word whose next byte address is a multiple of PAGE_BYTES. Remaining words start a new request, readiness and write-enable cycle. The number of bursts equals the number of pages the run touches.
- R9: After the last data bit of a burst, `ee_sck` stays low for at least WAIT_CYCLES cycles before release. On release, `ee_cs_n` goes high with `ee_sck` low, and `bus_req` falls on a later cycle.
- R10: `xfer_done` is a single-cycle pulse, raised once per accepted transfer. A start that arrives while a transfer is in flight is ignored.
- R11: After reset `ee_cs_n` is high, and `ee_sck`, `ee_mosi`, `bus_req`, `word_take` and `xfer_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start pulse for a transfer |
| xfer_offset | input | 16 | First word index |
| xfer_count | input | 16 | Number of words |
| word_in | input | 16 | Current data word from the host |
| word_take | output | 1 | Word consumed; host advances |
| xfer_done | output | 1 | End-of-transfer pulse |
| xfer_err | output | 1 | Error flag, valid with done |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Bus access grant |
| ee_cs_n | output | 1 | Device select, active low |
| ee_sck | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to device |
| ee_miso | input | 1 | Serial data from device |

## Verification
The assertions assume that `bus_gnt` only answers a request that is already standing. They also assume the host keeps `word_in` valid until it sees `word_take`. The bench meets the first assumption by registering the grant from `bus_req` behind an enable. It meets the second by indexing a word array with a counter that advances only on `word_take`. The device model changes `ee_miso` only on falling `ee_sck` edges, so status bits are stable whenever the block captures them. Random offsets are clipped to the device size, except in the directed cases that deliberately break the range check.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [1:0] {SH_OUT, SH_IN, SH_PULSE} sh_op_e;

    typedef struct packed {
        sh_op_e      op;
        logic [4:0]  nbits;
        logic [15:0] data;
    } sh_cmd_t;

    typedef enum logic [2:0] {SS_IDLE, SS_SET, SS_HI, SS_LO, SS_PH, SS_PL} sh_state_e;

    typedef enum logic [4:0] {
        W_IDLE, W_ACQ, W_RDOP, W_RDIN, W_RDCHK, W_RDPUL, W_SB1, W_WREN,
        W_SB2, W_WROP, W_WRAD, W_WRDAT, W_SB3, W_WAIT, W_RELCS, W_RELRQ, W_FIN
    } wr_state_e;

    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_A8    = 8'h08;

    function automatic logic [15:0] swap_bytes(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/eepw_argchk.sv
module eepw_argchk #(
    parameter int DEV_WORDS = 256
) (
    input  logic [15:0] offset,
    input  logic [15:0] count,
    output logic        bad
);
    localparam logic [16:0] DEV = 17'(DEV_WORDS);

    logic [16:0] room;

    always_comb begin
        room = DEV - {1'b0, offset};
        bad  = ({1'b0, offset} >= DEV) || (count == 16'd0) || ({1'b0, count} > room);
    end
endmodule

// File: rtl/eepw_shifter.sv
module eepw_shifter
    import eepw_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  sh_cmd_t cmd,
    input  logic    miso,
    output logic    sck,
    output logic    mosi,
    output logic    cs_pulse,
    output logic    done,
    output logic [7:0] rx_byte
);
    localparam int CW = $clog2(PHASE_CYC + 1);

    sh_state_e   st_q;
    logic [CW-1:0] cnt_q;
    logic [15:0] sh_q;
    logic [4:0]  left_q;
    logic        in_q;
    logic        last_ph;
    logic [15:0] load_val;

    always_comb begin
        last_ph  = (cnt_q == CW'(PHASE_CYC - 1));
        load_val = cmd.data << (5'd16 - cmd.nbits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SS_IDLE; cnt_q <= '0; sh_q <= '0; left_q <= '0;
            in_q <= 1'b0; sck <= 1'b0; mosi <= 1'b0; cs_pulse <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SS_IDLE: if (cmd_valid) begin
                    cnt_q  <= '0;
                    left_q <= cmd.nbits;
                    in_q   <= (cmd.op == SH_IN);
                    if (cmd.op == SH_PULSE) begin
                        cs_pulse <= 1'b1;
                        st_q     <= SS_PH;
                    end else begin
                        sh_q <= load_val;
                        mosi <= (cmd.op == SH_OUT) ? load_val[15] : 1'b0;
                        st_q <= SS_SET;
                    end
                end
                SS_SET: if (last_ph) begin
                    cnt_q <= '0; sck <= 1'b1; st_q <= SS_HI;
                end else cnt_q <= cnt_q + 1'b1;
                SS_HI: if (last_ph) begin
                    cnt_q <= '0; sck <= 1'b0;
                    sh_q  <= {sh_q[14:0], in_q ? miso : 1'b0};
                    st_q  <= SS_LO;
                end else cnt_q <= cnt_q + 1'b1;
                SS_LO: if (last_ph) begin
                    cnt_q <= '0;
                    if (left_q == 5'd1) begin
                        mosi <= 1'b0; done <= 1'b1; st_q <= SS_IDLE;
                    end else begin
                        left_q <= left_q - 1'b1;
                        mosi   <= in_q ? 1'b0 : sh_q[15];
                        st_q   <= SS_SET;
                    end
                end else cnt_q <= cnt_q + 1'b1;
                SS_PH: if (last_ph) begin
                    cnt_q <= '0; cs_pulse <= 1'b0; st_q <= SS_PL;
                end else cnt_q <= cnt_q + 1'b1;
                SS_PL: if (last_ph) begin
                    cnt_q <= '0; done <= 1'b1; st_q <= SS_IDLE;
                end else cnt_q <= cnt_q + 1'b1;
                default: st_q <= SS_IDLE;
            endcase
        end
    end

    assign rx_byte = sh_q[7:0];

    // R1
    read_mosi_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != SS_IDLE && in_q) |-> !mosi);
    // R1
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));
    // R9
    pulse_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_pulse |-> !sck);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int DEV_WORDS   = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int ADDR_BITS   = 8,
    parameter int OPC_BITS    = 8,
    parameter int PHASE_CYC   = 4,
    parameter int GNT_TRIES   = 1000,
    parameter int RDY_TRIES   = 200,
    parameter int WAIT_CYCLES = 1000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_start,
    input  logic [15:0] xfer_offset,
    input  logic [15:0] xfer_count,
    input  logic [15:0] word_in,
    output logic        word_take,
    output logic        xfer_done,
    output logic        xfer_err,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        ee_cs_n,
    output logic        ee_sck,
    output logic        ee_mosi,
    input  logic        ee_miso
);
    localparam int WPP = PAGE_BYTES / 2;
    localparam int GW  = $clog2(GNT_TRIES + 1);
    localparam int RW  = $clog2(RDY_TRIES + 1);
    localparam int TW  = $clog2(WAIT_CYCLES + 1);

    wr_state_e   st_q;
    logic [16:0] word_q, left_q, bstart_q, nxt_word;
    logic [GW-1:0] gtry_q;
    logic [RW-1:0] rtry_q;
    logic [TW-1:0] wcnt_q;
    logic        issued_q, cs_lvl_q, bad;
    logic        cmd_valid, sh_done, sh_pulse, is_sh, page_end;
    sh_cmd_t     cmd;
    logic [7:0]  rx_byte, wr_opc;
    logic [16:0] byte_addr;

    eepw_argchk #(.DEV_WORDS(DEV_WORDS)) u_chk (
        .offset(xfer_offset), .count(xfer_count), .bad(bad));

    eepw_shifter #(.PHASE_CYC(PHASE_CYC)) u_sh (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .miso(ee_miso),
        .sck(ee_sck), .mosi(ee_mosi), .cs_pulse(sh_pulse), .done(sh_done), .rx_byte(rx_byte));

    always_comb begin
        nxt_word  = word_q + 17'd1;
        page_end  = ((nxt_word & 17'(WPP - 1)) == 17'd0);
        byte_addr = {word_q[15:0], 1'b0};
        wr_opc    = OPC_WRITE | (((ADDR_BITS == 8) && (bstart_q >= 17'd128)) ? OPC_A8 : 8'h00);
        cmd       = '{op: SH_OUT, nbits: 5'(OPC_BITS), data: 16'h0000};
        is_sh     = 1'b1;
        case (st_q)
            W_RDOP:  cmd.data = {8'h00, OPC_RDSR};
            W_RDIN:  cmd = '{op: SH_IN, nbits: 5'd8, data: 16'h0000};
            W_WREN:  cmd.data = {8'h00, OPC_WREN};
            W_WROP:  cmd.data = {8'h00, wr_opc};
            W_WRAD:  cmd = '{op: SH_OUT, nbits: 5'(ADDR_BITS), data: byte_addr[15:0]};
            W_WRDAT: cmd = '{op: SH_OUT, nbits: 5'd16, data: swap_bytes(word_in)};
            W_RDPUL, W_SB1, W_SB2, W_SB3: cmd.op = SH_PULSE;
            default: is_sh = 1'b0;
        endcase
        cmd_valid = is_sh && !issued_q;
        word_take = (st_q == W_WRDAT) && !issued_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= W_IDLE; word_q <= '0; left_q <= '0; bstart_q <= '0;
            gtry_q <= '0; rtry_q <= '0; wcnt_q <= '0; issued_q <= 1'b0;
            cs_lvl_q <= 1'b1; bus_req <= 1'b0; xfer_done <= 1'b0; xfer_err <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (cmd_valid) issued_q <= 1'b1;
            else if (sh_done) issued_q <= 1'b0;
            case (st_q)
                W_IDLE: if (xfer_start) begin
                    if (bad) begin
                        xfer_done <= 1'b1; xfer_err <= 1'b1;
                    end else begin
                        xfer_err <= 1'b0;
                        word_q   <= {1'b0, xfer_offset};
                        left_q   <= {1'b0, xfer_count};
                        st_q     <= W_ACQ;
                    end
                end
                W_ACQ: if (!bus_req) bus_req <= 1'b1;
                else if (bus_gnt) begin
                    cs_lvl_q <= 1'b0; gtry_q <= '0; rtry_q <= '0;
                    bstart_q <= word_q; st_q <= W_RDOP;
                end else if (gtry_q == GW'(GNT_TRIES - 1)) begin
                    bus_req <= 1'b0; xfer_err <= 1'b1; gtry_q <= '0; st_q <= W_FIN;
                end else gtry_q <= gtry_q + 1'b1;
                W_RDOP:  if (sh_done) st_q <= W_RDIN;
                W_RDIN:  if (sh_done) st_q <= W_RDCHK;
                W_RDCHK: if (!rx_byte[0]) st_q <= W_SB1;
                else if (rtry_q == RW'(RDY_TRIES - 1)) begin
                    xfer_err <= 1'b1; st_q <= W_RELCS;
                end else begin
                    rtry_q <= rtry_q + 1'b1; st_q <= W_RDPUL;
                end
                W_RDPUL: if (sh_done) st_q <= W_RDOP;
                W_SB1:   if (sh_done) st_q <= W_WREN;
                W_WREN:  if (sh_done) st_q <= W_SB2;
                W_SB2:   if (sh_done) st_q <= W_WROP;
                W_WROP:  if (sh_done) st_q <= W_WRAD;
                W_WRAD:  if (sh_done) st_q <= W_WRDAT;
                W_WRDAT: if (sh_done) begin
                    word_q <= nxt_word;
                    left_q <= left_q - 17'd1;
                    if (page_end) st_q <= W_SB3;
                    else if (left_q == 17'd1) st_q <= W_WAIT;
                end
                W_SB3:   if (sh_done) st_q <= W_WAIT;
                W_WAIT:  if (wcnt_q == TW'(WAIT_CYCLES - 1)) begin
                    wcnt_q <= '0; st_q <= W_RELCS;
                end else wcnt_q <= wcnt_q + 1'b1;
                W_RELCS: begin cs_lvl_q <= 1'b1; st_q <= W_RELRQ; end
                W_RELRQ: begin
                    bus_req <= 1'b0;
                    st_q    <= (xfer_err || left_q == 17'd0) ? W_FIN : W_ACQ;
                end
                W_FIN:   begin xfer_done <= 1'b1; st_q <= W_IDLE; end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    assign ee_cs_n = cs_lvl_q | sh_pulse;

    // R2
    reject_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == W_IDLE && xfer_start && bad) |=> (xfer_done && xfer_err && !bus_req));
    // R3
    select_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> ee_cs_n);
    // R9
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> (ee_cs_n && !ee_sck));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
    localparam int DEV = 256, PB = 8, WPP = PB / 2;
    localparam int RDY = 5, WAITC = 300, LIMIT = 20000;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] s_off = '0, s_cnt = '0;
    logic take, done, err, req, cs_n, sck, mosi, miso;
    logic gnt = 1'b0, gnt_en = 1'b1;
    logic [15:0] src [0:15];
    int src_idx = 0;

    int tests = 0, fails = 0;
    logic [7:0] mem [0:511];
    logic [7:0] exp_mem [0:511];
    int m_nb = 0, m_nf = 0, m_k = 0, m_wr = 0, m_rdsr = 0, m_err = 0, m_csfall = 0;
    int busy_left = 0;
    logic [7:0] m_op = 8'h00, m_stat = 8'h00;
    logic [31:0] m_sh = '0;
    logic m_wel = 1'b0;
    logic [8:0] m_addr = '0;
    int done_cnt = 0, take_cnt = 0, low_run = 0, min_gap = 0;
    logic prev_req = 1'b0;

    always #5 clk = ~clk;

    eeprom_page_writer #(.DEV_WORDS(DEV), .PAGE_BYTES(PB), .ADDR_BITS(8), .OPC_BITS(8),
        .PHASE_CYC(2), .GNT_TRIES(12), .RDY_TRIES(RDY), .WAIT_CYCLES(WAITC)) u0 (
        .clk(clk), .rst(rst), .xfer_start(start), .xfer_offset(s_off), .xfer_count(s_cnt),
        .word_in(src[src_idx[3:0]]), .word_take(take), .xfer_done(done), .xfer_err(err),
        .bus_req(req), .bus_gnt(gnt), .ee_cs_n(cs_n), .ee_sck(sck), .ee_mosi(mosi),
        .ee_miso(miso));

    always @(posedge clk) begin
        gnt <= req & gnt_en;
        if (take) begin src_idx <= src_idx + 1; take_cnt++; end
        if (done) done_cnt++;
        if (prev_req && !req && low_run < min_gap) min_gap = low_run;
        if (!req || sck) low_run = 0; else low_run++;
        prev_req = req;
    end

    // device model
    assign miso = (m_op == 8'h05 && m_nf >= 8 && m_nf < 16) ? m_stat[3'(15 - m_nf)] : 1'b0;

    always @(negedge cs_n) begin
        m_nb = 0; m_nf = 0; m_k = 0; m_op = 8'h00; m_csfall++;
    end
    always @(posedge cs_n) if ((m_op & 8'hF7) == 8'h02) m_wel = 1'b0;
    always @(negedge sck) if (!cs_n) m_nf++;
    always @(posedge sck) if (!cs_n) begin
        m_sh = {m_sh[30:0], mosi};
        m_nb++;
        if (m_nb == 8) begin
            m_op = m_sh[7:0];
            if (m_op == 8'h06) m_wel = 1'b1;
            else if (m_op == 8'h05) begin
                m_rdsr++;
                m_stat = 8'hF2 | ((busy_left > 0) ? 8'h01 : 8'h00);
                if (busy_left > 0) busy_left--;
            end else if ((m_op & 8'hF7) == 8'h02) begin
                m_wr++;
                if (!m_wel) m_err++;
            end else m_err++;
        end else if (m_nb > 8) begin
            if (m_op == 8'h05 && mosi) m_err++;
            if ((m_op & 8'hF7) == 8'h02) begin
                if (m_nb == 16) m_addr = {m_op[3], m_sh[7:0]};
                else if (m_nb > 16 && (m_nb - 16) % 8 == 0) begin
                    if (m_wel)
                        mem[(int'(m_addr) & ~(PB - 1)) | ((int'(m_addr) + m_k) & (PB - 1))] = m_sh[7:0];
                    m_k++;
                end
            end
        end
    end

    function automatic int pages(input int off, input int cnt);
        return ((off + cnt - 1) / WPP) - (off / WPP) + 1;
    endfunction

    task automatic chk(input bit ok, input string req_s, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
        end
    endtask

    task automatic cmp_mem(input string req_s);
        int bad = 0, first = -1;
        for (int i = 0; i < 512; i++)
            if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
        chk(bad == 0, req_s, bad, 0);
        if (bad != 0) $display("  first mismatch at byte %0d", first);
    endtask

    task automatic run(input int off, input int cnt, output logic e, output int wr0, output int tk0);
        int n = 0;
        for (int i = 0; i < 16; i++) src[i] = 16'($urandom);
        src_idx = 0;
        wr0 = m_wr; tk0 = take_cnt; min_gap = 1 << 30;
        @(negedge clk); start = 1'b1; s_off = 16'(off); s_cnt = 16'(cnt);
        @(negedge clk); start = 1'b0;
        while (!done && n < LIMIT) begin @(negedge clk); n++; end
        if (n >= LIMIT) chk(1'b0, "watchdog", n, LIMIT);
        e = err;
        @(negedge clk);
    endtask

    task automatic expect_ok(input int off, input int cnt, input string tag);
        logic e; int wr0, tk0;
        run(off, cnt, e, wr0, tk0);
        for (int i = 0; i < cnt; i++) begin
            exp_mem[2 * (off + i)]     = src[i][7:0];
            exp_mem[2 * (off + i) + 1] = src[i][15:8];
        end
        chk(e == 1'b0, {tag, " R2 no error"}, int'(e), 0);
        cmp_mem({tag, " R1 R5 R6 R7 memory"});
        chk(take_cnt - tk0 == cnt, {tag, " R7 words taken"}, take_cnt - tk0, cnt);
        chk(m_wr - wr0 == pages(off, cnt), {tag, " R8 bursts"}, m_wr - wr0, pages(off, cnt));
        chk(min_gap >= WAITC, {tag, " R9 write wait"}, min_gap, WAITC);
        chk(m_err == 0, {tag, " R1 R5 model protocol"}, m_err, 0);
    endtask

    task automatic expect_bad(input int off, input int cnt, input string tag);
        logic e; int wr0, tk0, cs0;
        cs0 = m_csfall;
        run(off, cnt, e, wr0, tk0);
        chk(e == 1'b1, {tag, " R2 rejected"}, int'(e), 1);
        chk(m_csfall == cs0 && !req, {tag, " R2 no select"}, m_csfall - cs0, 0);
    endtask

    initial begin
        logic e; int wr0, tk0, cs0, r0, d0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
        for (int i = 0; i < 16; i++) src[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(cs_n && !sck && !mosi && !req && !take && !done, "R11 reset state",
            int'({cs_n, sck, mosi, req, take, done}), 32);

        expect_ok(0, 1, "single");
        expect_ok(2, 5, "cross page");
        expect_ok(130, 3, "R6 high half");
        expect_ok(126, 4, "R6 boundary 127/128");
        expect_ok(252, 4, "end of device");
        expect_ok(255, 1, "last word");

        expect_bad(0, 0, "count zero");
        expect_bad(256, 1, "offset out");
        expect_bad(250, 7, "overrun");

        // R3 grant never arrives
        gnt_en = 1'b0; cs0 = m_csfall;
        run(20, 2, e, wr0, tk0);
        chk(e == 1'b1, "R3 grant timeout error", int'(e), 1);
        chk(m_csfall == cs0 && !req, "R3 no select, req dropped", m_csfall - cs0, 0);
        gnt_en = 1'b1;

        // R4 busy a few polls then ready; upper status bits set
        busy_left = 3; r0 = m_rdsr;
        expect_ok(40, 2, "R4 busy retry");
        chk(m_rdsr - r0 == 4, "R4 poll count", m_rdsr - r0, 4);

        // R4 device never ready
        busy_left = 1000; r0 = m_rdsr;
        run(60, 2, e, wr0, tk0);
        chk(e == 1'b1, "R4 ready timeout error", int'(e), 1);
        chk(m_rdsr - r0 == RDY, "R4 poll limit", m_rdsr - r0, RDY);
        chk(m_wr == wr0 && !req, "R4 nothing written", m_wr - wr0, 0);
        cmp_mem("R4 memory untouched");
        busy_left = 0;

        // R10 second start while busy is ignored
        for (int i = 0; i < 16; i++) src[i] = 16'($urandom);
        src_idx = 0; d0 = done_cnt;
        @(negedge clk); start = 1'b1; s_off = 16'd16; s_cnt = 16'd6;
        @(negedge clk); start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1; s_off = 16'd200; s_cnt = 16'd1;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n < LIMIT && !done; n++) @(negedge clk);
        repeat (50) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            exp_mem[2 * (16 + i)] = src[i][7:0];
            exp_mem[2 * (16 + i) + 1] = src[i][15:8];
        end
        chk(done_cnt - d0 == 1, "R10 one done", done_cnt - d0, 1);
        cmp_mem("R10 ignored start left no write");

        // random transfers
        for (int t = 0; t < 14; t++) begin
            int off = int'($urandom % DEV);
            int cnt = 1 + int'($urandom % 8);
            if (off + cnt > DEV) cnt = DEV - off;
            expect_ok(off, cnt, "random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1900000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule